// File: doc/BRIEF.md
# DRAM Column Address Pin Mapper

This block takes the column portion of a byte address and lays it onto the thirteen address pins of a DRAM device that sits behind a 64-bit data bus. A 3-bit page-size code selects how many column bits the device uses, from seven (1K page) up to twelve (32K page). The three lowest byte-address bits select a byte inside one bus beat, so they never reach the pins. The first column bit on the pins is byte-address bit 3, and it lands on pin 0.

Pin 10 belongs to the auto-precharge request on every valid code. Devices with eleven or twelve column bits therefore have their upper column bits moved up by one pin so that they step around pin 10. Codes 6 and 7 mark a slot that is unused or empty. For those codes the pins are held at zero and an invalid flag is raised. An optional output register, chosen by a parameter, adds one clock of latency.

Top module: `dram_col_pin_mapper`

## Requirements
- R1: For page codes 0 to 3 (7 + code column bits), pin i carries byte-address bit 3+i when i is below the column-bit count. Every other pin except pin 10 is 0.
- R2: Byte-address bits 0, 1 and 2 never affect any pin.
- R3: For page codes 0 to 5, pin 10 equals the auto-precharge request input.
- R4: For page code 4 (11 column bits), pins 0 to 9 carry address bits 3 to 12, pin 11 carries address bit 13, and pin 12 is 0.
- R5: For page code 5 (12 column bits), pins 0 to 9 carry address bits 3 to 12, pin 11 carries bit 13, and pin 12 carries bit 14.
- R6: For page codes 0 to 3, pins 11 and 12 are 0.
- R7: For page codes 6 and 7, all thirteen pins are 0 whatever the address and auto-precharge inputs are, and the invalid flag is 1.
- R8: For page codes 0 to 5, the invalid flag is 0.
- R9: With the output register enabled (the default), the outputs reflect the inputs present at the previous rising clock edge. While reset is low, the outputs are all pins 0 with the invalid flag at 1.
- R10: With the output register disabled, the outputs follow the inputs in the same cycle and use the same mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| col_addr_i | input | 15 | Byte-level column address (bits 0 to 14) |
| page_code_i | input | 3 | Page-size code: 0..5 give 7..12 column bits, 6 is unused, 7 is off |
| auto_pre_i | input | 1 | Auto-precharge request, placed on pin 10 |
| dram_addr_o | output | 13 | DRAM address pins |
| code_invalid_o | output | 1 | High when the page code is 6 or 7 |

## Verification
On page codes 4 and 5, the auto-precharge flag and the column bits that step over pin 10 meet in the same cycle. The bench provokes this with auto-precharge set while walking a single one across every address bit and while driving all-ones addresses. Pin 10 must follow only the request, and address bit 13 must appear on pin 11 and nowhere else. Expected pin words are built arithmetically: the column field is masked, split at ten bits, and the upper part is shifted up one pin with the flag inserted. A combinational copy of the block is checked in the same cycle as the registered one.

// File: rtl/dcpm_pkg.sv
package dcpm_pkg;
   localparam int unsigned CODE_BITS = 3;
   typedef logic [CODE_BITS-1:0] page_code_t;
   typedef enum logic [CODE_BITS-1:0] {
      PG_1K    = 3'd0,
      PG_2K    = 3'd1,
      PG_4K    = 3'd2,
      PG_8K    = 3'd3,
      PG_16K   = 3'd4,
      PG_32K   = 3'd5,
      PG_SPARE = 3'd6,
      PG_OFF   = 3'd7
   } page_code_e;
endpackage

// File: rtl/dcpm_code_decode.sv
module dcpm_code_decode #(
   parameter int unsigned MIN_COL   = 7,
   parameter int unsigned NUM_CODES = 6,
   parameter int unsigned CNT_W     = 4
) (
   input  dcpm_pkg::page_code_t code_i,
   output logic                 valid_o,
   output logic [CNT_W-1:0]     ncol_o
);
   always_comb begin
      valid_o = (int'(code_i) < int'(NUM_CODES));
      ncol_o  = valid_o ? CNT_W'(MIN_COL + int'(code_i)) : '0;
   end
endmodule

// File: rtl/dcpm_lane_mask.sv
module dcpm_lane_mask #(
   parameter int unsigned MAX_COL = 12,
   parameter int unsigned CNT_W   = 4
) (
   input  logic [CNT_W-1:0]   ncol_i,
   output logic [MAX_COL-1:0] mask_o
);
   for (genvar j = 0; j < MAX_COL; j++) begin : g_lane
      assign mask_o[j] = (ncol_i > CNT_W'(j));
   end
endmodule

// File: rtl/dcpm_pin_router.sv
module dcpm_pin_router #(
   parameter int unsigned PIN_W    = 13,
   parameter int unsigned AP_PIN   = 10,
   parameter int unsigned MAX_COL  = 12,
   parameter int unsigned LSB_DROP = 3,
   parameter int unsigned COL_W    = 15
) (
   input  logic [COL_W-1:0]   addr_i,
   input  logic [MAX_COL-1:0] mask_i,
   input  logic               ap_i,
   input  logic               valid_i,
   output logic [PIN_W-1:0]   pins_o
);
   logic unused_low_bits;
   assign unused_low_bits = ^addr_i[LSB_DROP-1:0];

   for (genvar p = 0; p < PIN_W; p++) begin : g_pin
      if (p == AP_PIN) begin : g_ap
         assign pins_o[p] = valid_i & ap_i;
      end else if (p < AP_PIN) begin : g_low
         if (p < MAX_COL) begin : g_used
            assign pins_o[p] = mask_i[p] & addr_i[LSB_DROP+p];
         end else begin : g_idle
            assign pins_o[p] = 1'b0;
         end
      end else begin : g_high
         if (p - 1 < MAX_COL) begin : g_used
            assign pins_o[p] = mask_i[p-1] & addr_i[LSB_DROP+p-1];
         end else begin : g_idle
            assign pins_o[p] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/dcpm_out_stage.sv
module dcpm_out_stage #(
   parameter int unsigned W       = 14,
   parameter bit          REG_OUT = 1'b1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o <= RST_VAL;
         else         q_o <= d_i;
      end
   end else begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk_i ^ rst_ni;
      assign q_o = d_i;
   end
endmodule

// File: rtl/dram_col_pin_mapper.sv
module dram_col_pin_mapper #(
   parameter int unsigned PIN_W          = 13,
   parameter int unsigned AP_PIN         = 10,
   parameter int unsigned BUS_BYTES_LOG2 = 3,
   parameter int unsigned MIN_COL        = 7,
   parameter int unsigned NUM_CODES      = 6,
   parameter bit          REG_OUT        = 1'b1,
   localparam int unsigned MAX_COL       = MIN_COL + NUM_CODES - 1,
   localparam int unsigned COL_W         = BUS_BYTES_LOG2 + MAX_COL
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [COL_W-1:0]           col_addr_i,
   input  logic [dcpm_pkg::CODE_BITS-1:0] page_code_i,
   input  logic                       auto_pre_i,
   output logic [PIN_W-1:0]           dram_addr_o,
   output logic                       code_invalid_o
);
   localparam int unsigned CNT_W      = $clog2(MAX_COL + 1);
   localparam int unsigned NEED_PINS  = MAX_COL + ((MAX_COL >= AP_PIN) ? 1 : 0);
   localparam int unsigned SPILL_CODE = AP_PIN + 1 - MIN_COL;
   localparam logic [PIN_W:0] RST_WORD = {1'b1, {PIN_W{1'b0}}};

   if (NUM_CODES > (1 << dcpm_pkg::CODE_BITS)) begin : g_chk_codes
      $error("page code field too narrow for NUM_CODES");
   end
   if (AP_PIN >= PIN_W) begin : g_chk_ap
      $error("auto-precharge pin outside the pin field");
   end
   if (PIN_W < NEED_PINS) begin : g_chk_pins
      $error("pin field too narrow for the largest page");
   end
   if (BUS_BYTES_LOG2 == 0) begin : g_chk_bus
      $error("bus width must exceed one byte");
   end

   logic               code_ok;
   logic [CNT_W-1:0]   ncol;
   logic [MAX_COL-1:0] lane_mask;
   logic [PIN_W-1:0]   pins_next;

   dcpm_code_decode #(
      .MIN_COL(MIN_COL), .NUM_CODES(NUM_CODES), .CNT_W(CNT_W)
   ) u_decode (
      .code_i(page_code_i), .valid_o(code_ok), .ncol_o(ncol)
   );

   dcpm_lane_mask #(
      .MAX_COL(MAX_COL), .CNT_W(CNT_W)
   ) u_mask (
      .ncol_i(ncol), .mask_o(lane_mask)
   );

   dcpm_pin_router #(
      .PIN_W(PIN_W), .AP_PIN(AP_PIN), .MAX_COL(MAX_COL),
      .LSB_DROP(BUS_BYTES_LOG2), .COL_W(COL_W)
   ) u_router (
      .addr_i(col_addr_i), .mask_i(lane_mask), .ap_i(auto_pre_i),
      .valid_i(code_ok), .pins_o(pins_next)
   );

   dcpm_out_stage #(
      .W(PIN_W + 1), .REG_OUT(REG_OUT), .RST_VAL(RST_WORD)
   ) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .d_i({~code_ok, pins_next}),
      .q_o({code_invalid_o, dram_addr_o})
   );

   logic in_range, below_spill;
   assign in_range    = (int'(page_code_i) < int'(NUM_CODES));
   assign below_spill = (int'(page_code_i) < int'(SPILL_CODE));

   // R7: a flagged code never leaves anything on the pins
   p_off_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_invalid_o |-> (dram_addr_o == '0));

   if (REG_OUT) begin : g_chk_reg
      p_bad_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !in_range |=> code_invalid_o);
      p_good_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_range |=> !code_invalid_o);
      p_ap_pin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_range |=> (dram_addr_o[AP_PIN] == $past(auto_pre_i)));
      if (PIN_W > AP_PIN + 1) begin : g_up
         p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            below_spill |=> (dram_addr_o[PIN_W-1:AP_PIN+1] == '0));
      end
   end else begin : g_chk_comb
      p_bad_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !in_range |-> code_invalid_o);
      p_good_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_range |-> !code_invalid_o);
      p_ap_pin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_range |-> (dram_addr_o[AP_PIN] == auto_pre_i));
   end
endmodule

// File: tb/tb_dram_col_pin_mapper.sv
module tb_dram_col_pin_mapper;
   import dcpm_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] col_addr = '1;
   logic [2:0]  code = PG_OFF;
   logic        ap = 1'b1;
   logic [12:0] pins_r, pins_c;
   logic        inv_r, inv_c;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [12:0] prev_exp;

   always #4 clk = ~clk;

   dram_col_pin_mapper #(.REG_OUT(1'b1)) dut (
      .clk_i(clk), .rst_ni(rst_n), .col_addr_i(col_addr), .page_code_i(code),
      .auto_pre_i(ap), .dram_addr_o(pins_r), .code_invalid_o(inv_r));

   dram_col_pin_mapper #(.REG_OUT(1'b0)) dut_c (
      .clk_i(clk), .rst_ni(rst_n), .col_addr_i(col_addr), .page_code_i(code),
      .auto_pre_i(ap), .dram_addr_o(pins_c), .code_invalid_o(inv_c));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (code %0d addr %0h ap %0b)",
                  tag, act, exp, code, col_addr, ap);
      end
   endtask

   function automatic logic [12:0] exp_pins(logic [14:0] a, logic [2:0] c, logic f);
      int unsigned n, col, r;
      if (c > 3'd5) return '0;
      n   = 7 + int'(c);
      col = (int'(a) >> 3) & ((1 << n) - 1);
      r   = (col & 1023) | ((col >> 10) << 11) | (int'(f) << 10);
      return r[12:0];
   endfunction

   task automatic apply(input logic [14:0] a, input logic [2:0] c, input logic f,
                        input bit low_only);
      logic [12:0] e;
      string       tag;
      @(negedge clk);
      col_addr = a; code = c; ap = f;
      e = exp_pins(a, c, f);
      #1;
      chk("R9 previous value held before edge", 32'(pins_r), 32'(prev_exp));
      chk("R10 comb pins", 32'(pins_c), 32'(e));
      chk("R10 comb flag", 32'(inv_c), 32'(c > 3'd5));
      @(posedge clk);
      #1;
      if (c > 3'd5)        tag = "R7";
      else if (low_only)   tag = "R2";
      else if (c == 3'd5)  tag = "R5";
      else if (c == 3'd4)  tag = "R4";
      else                 tag = "R1";
      chk(tag, 32'(pins_r), 32'(e));
      if (c <= 3'd5) begin
         chk("R3 pin10", 32'(pins_r[10]), 32'(f));
         chk("R8 flag", 32'(inv_r), 32'd0);
      end else begin
         chk("R7 flag", 32'(inv_r), 32'd1);
      end
      if (c < 3'd4) chk("R6 upper pins", 32'(pins_r[12:11]), 32'd0);
      prev_exp = e;
   endtask

   initial begin
      int unsigned x;
      repeat (3) @(posedge clk);
      #1;
      chk("R9 reset pins", 32'(pins_r), 32'd0);
      chk("R9 reset flag", 32'(inv_r), 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      prev_exp = '0;
      x = 32'h1234_5678;
      for (int c = 0; c < 8; c++) begin
         for (int f = 0; f < 2; f++) begin
            apply(15'h7fff, 3'(c), f[0], 1'b0);
            for (int b = 0; b < 15; b++) begin
               apply(15'(1 << b), 3'(c), f[0], b < 3);
            end
            apply(15'h0007, 3'(c), f[0], 1'b1);
            for (int k = 0; k < 8; k++) begin
               x = x * 32'd1103515245 + 32'd12345;
               apply(15'(x >> 9), 3'(c), f[0], 1'b0);
            end
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule